// File: doc/BRIEF.md
# Double-Precision to Integer Converter

This block turns a 64-bit binary floating-point operand into a 32-bit or 64-bit integer, signed or unsigned. It rounds with the rounding mode supplied alongside the operand, or with round-toward-zero when the truncate select is set. Together with the integer it reports two flags: inexact and invalid-conversion. The rules for which flag wins are strict, and they are covered below.

The block is a two-stage registered pipeline. The first stage unpacks the operand and aligns its significand into a 64-bit integer part, a guard bit and a sticky bit. The second stage applies the rounding increment, checks the destination range and picks the result and the flags. It accepts one operand per cycle. The upstream logic owns the flags once they leave the block.

Top module: `fcvt_to_int`

## Requirements
- R1: A conversion presented with `in_valid` high at clock edge N appears on the outputs with `out_valid` high after clock edge N+1. With no new request, `out_valid` is low one cycle later. Back-to-back requests are accepted every cycle.
- R2: Rounding-mode code 00 rounds to the nearest integer, and ties go to the even integer. For example, 2.5 gives 2, 3.5 gives 4 and -2.5 gives -2.
- R3: Rounding-mode code 01 rounds toward zero, code 10 rounds toward +infinity and code 11 rounds toward -infinity.
- R4: When `in_trunc` is 1, the block rounds toward zero whatever the value of `in_rmode`.
- R5: `in_dword` = 0 selects a 32-bit destination. In that case the low 32 bits hold the value, and the upper 32 bits are sign-extended for signed results and zero for unsigned results. `in_dword` = 1 selects a 64-bit destination.
- R6: If the rounded value lies outside the destination range, `out_invalid` is 1 and `out_inexact` is 0. The result saturates to the destination maximum for positive values and to the destination minimum for negative values. Infinities are treated the same way.
- R7: In an unsigned conversion, a negative value that rounds to zero gives result 0 with only `out_inexact` set. A negative value that rounds to a non-zero magnitude is out of range: it gives 0 with only `out_invalid` set.
- R8: Any NaN input, quiet or signalling, sets `out_invalid` and clears `out_inexact`. The result is the most negative signed value of the destination, or 0 for unsigned destinations.
- R9: `out_inexact` is 1 exactly when the result is in range and at least one discarded fraction bit is non-zero. Exact conversions, including -0.0 to unsigned, raise no flag.
- R10: A denormal input converts to 0, +1 or -1 as the rounding mode dictates, with `out_inexact` set.
- R11: While `rst` is high, and after it, `out_valid`, `out_result`, `out_inexact` and `out_invalid` are all 0 until a new conversion arrives.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Request strobe |
| in_op | input | 64 | Double-precision operand |
| in_rmode | input | 2 | Rounding mode: 00 nearest-even, 01 zero, 10 +inf, 11 -inf |
| in_dword | input | 1 | 1 = 64-bit destination, 0 = 32-bit |
| in_signed | input | 1 | 1 = signed destination |
| in_trunc | input | 1 | 1 = force round-toward-zero |
| out_valid | output | 1 | Result strobe, two cycles after the request |
| out_result | output | 64 | Integer result |
| out_inexact | output | 1 | Inexact flag |
| out_invalid | output | 1 | Invalid-conversion flag |

## Verification
The rounding increment and the range check act in the same cycle, so a single operand can raise the question of which flag takes precedence. The bench provokes this with operands whose fraction is discarded and whose rounding carry pushes the magnitude past the limit. One example is 2147483647.5 converted to signed word with nearest-even. It must report invalid alone with the saturated result, while the same operand under round-toward-zero must report inexact alone. A second collision comes from negative operands in unsigned mode: the bench checks that a negative value rounding to zero gives inexact only, and that a negative value rounding to a magnitude of one gives invalid only.

// File: rtl/fcvt_pkg.sv
package fcvt_pkg;
  parameter int EXP_W  = 11;
  parameter int FRAC_W = 52;
  parameter int BIAS   = 1023;
  parameter int INT_W  = 64;
  localparam int SH_W  = $clog2(INT_W);

  typedef enum logic [1:0] {
    RM_NEAR = 2'b00,
    RM_ZERO = 2'b01,
    RM_PINF = 2'b10,
    RM_NINF = 2'b11
  } rmode_e;

  typedef struct packed {
    logic             neg;
    logic             nan;
    logic             big;
    logic [INT_W-1:0] mag;
    logic             grd;
    logic             stk;
  } align_t;
endpackage

// File: rtl/fcvt_align.sv
module fcvt_align
  import fcvt_pkg::*;
(
  input  logic [EXP_W+FRAC_W:0] op,
  output align_t                al
);
  localparam int PAD  = INT_W - FRAC_W;
  localparam int TOPZ = 2*INT_W - (FRAC_W + 1) - PAD;
  localparam int EW   = EXP_W + 2;

  logic [EXP_W-1:0]     exp_f;
  logic [FRAC_W-1:0]    frac;
  logic signed [EW-1:0] e_unb;
  logic [2*INT_W-1:0]   fixed, shifted;
  logic                 exp_max;

  assign exp_f   = op[EXP_W+FRAC_W-1:FRAC_W];
  assign frac    = op[FRAC_W-1:0];
  assign exp_max = &exp_f;
  assign e_unb   = $signed({2'b00, exp_f}) - EW'(BIAS);
  assign fixed   = {{TOPZ{1'b0}}, 1'b1, frac, {PAD{1'b0}}};
  assign shifted = fixed << e_unb[SH_W-1:0];

  always_comb begin
    al.neg = op[EXP_W+FRAC_W];
    al.nan = exp_max && (frac != '0);
    al.big = exp_max || (e_unb >= EW'(INT_W));
    al.mag = '0;
    al.grd = 1'b0;
    al.stk = 1'b0;
    if (!al.big && e_unb >= 0) begin
      al.mag = shifted[2*INT_W-1:INT_W];
      al.grd = shifted[INT_W-1];
      al.stk = |shifted[INT_W-2:0];
    end else if (e_unb == -1) begin
      al.grd = 1'b1;
      al.stk = |frac;
    end else if (!al.big) begin
      al.stk = (exp_f != '0) || (frac != '0);
    end
  end
endmodule

// File: rtl/fcvt_round.sv
module fcvt_round
  import fcvt_pkg::*;
(
  input  align_t           al,
  input  rmode_e           rm,
  input  logic             dword,
  input  logic             sgn,
  output logic [INT_W-1:0] res,
  output logic             inexact,
  output logic             invalid
);
  localparam int HW = INT_W / 2;

  logic             inc, lost, ovf;
  logic [INT_W:0]   mag_r, one, pos_lim, neg_lim;
  logic [7:0]       wbits;
  logic [INT_W-1:0] neg_sat;

  assign lost = al.grd | al.stk;

  always_comb begin
    unique case (rm)
      RM_NEAR: inc = al.grd & (al.stk | al.mag[0]);
      RM_ZERO: inc = 1'b0;
      RM_PINF: inc = ~al.neg & lost;
      default: inc = al.neg & lost;
    endcase
  end

  assign mag_r   = {1'b0, al.mag} + {{INT_W{1'b0}}, inc};
  assign one     = {{INT_W{1'b0}}, 1'b1};
  assign wbits   = dword ? 8'(INT_W) : 8'(HW);
  assign pos_lim = (one << (wbits - {7'b0, sgn})) - one;
  assign neg_lim = sgn ? (one << (wbits - 8'd1)) : '0;
  assign neg_sat = '0 - neg_lim[INT_W-1:0];
  assign ovf     = al.big | (al.neg ? (mag_r > neg_lim) : (mag_r > pos_lim));
  assign invalid = al.nan | ovf;
  assign inexact = ~invalid & lost;

  always_comb begin
    if (al.nan)      res = neg_sat;
    else if (ovf)    res = al.neg ? neg_sat : pos_lim[INT_W-1:0];
    else if (al.neg) res = '0 - mag_r[INT_W-1:0];
    else             res = mag_r[INT_W-1:0];
  end
endmodule

// File: rtl/fcvt_to_int.sv
module fcvt_to_int
  import fcvt_pkg::*;
(
  input  logic                    clk,
  input  logic                    rst,
  input  logic                    in_valid,
  input  logic [EXP_W+FRAC_W:0]   in_op,
  input  logic [1:0]              in_rmode,
  input  logic                    in_dword,
  input  logic                    in_signed,
  input  logic                    in_trunc,
  output logic                    out_valid,
  output logic [INT_W-1:0]        out_result,
  output logic                    out_inexact,
  output logic                    out_invalid
);
  align_t           al_c, s1_al;
  logic             s1_valid, s1_dword, s1_sgn;
  rmode_e           s1_rm;
  logic [INT_W-1:0] rd_res;
  logic             rd_nx, rd_nv;

  fcvt_align u_align (.op(in_op), .al(al_c));

  always_ff @(posedge clk) begin
    if (rst) begin
      s1_valid <= 1'b0;
      s1_al    <= '0;
      s1_rm    <= RM_NEAR;
      s1_dword <= 1'b0;
      s1_sgn   <= 1'b0;
    end else begin
      s1_valid <= in_valid;
      if (in_valid) begin
        s1_al    <= al_c;
        s1_rm    <= in_trunc ? RM_ZERO : rmode_e'(in_rmode);
        s1_dword <= in_dword;
        s1_sgn   <= in_signed;
      end
    end
  end

  fcvt_round u_round (
    .al(s1_al), .rm(s1_rm), .dword(s1_dword), .sgn(s1_sgn),
    .res(rd_res), .inexact(rd_nx), .invalid(rd_nv)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      out_valid   <= 1'b0;
      out_result  <= '0;
      out_inexact <= 1'b0;
      out_invalid <= 1'b0;
    end else begin
      out_valid <= s1_valid;
      if (s1_valid) begin
        out_result  <= rd_res;
        out_inexact <= rd_nx;
        out_invalid <= rd_nv;
      end
    end
  end

  AST_LATENCY: assert property (@(posedge clk) disable iff (rst)
    s1_valid |=> out_valid); // R1
  AST_FLAG_EXCL: assert property (@(posedge clk) disable iff (rst)
    !(out_inexact && out_invalid)); // R6
  AST_NAN_INVALID: assert property (@(posedge clk) disable iff (rst)
    s1_valid && s1_al.nan |=> out_invalid && !out_inexact); // R8
  AST_BIG_INVALID: assert property (@(posedge clk) disable iff (rst)
    s1_valid && s1_al.big |=> out_invalid); // R6
  AST_UNSIGNED_NEG: assert property (@(posedge clk) disable iff (rst)
    s1_valid && !s1_sgn && s1_al.neg |=> out_result == '0); // R7
endmodule

// File: tb/tb_fcvt_to_int.sv
module tb_fcvt_to_int;
  logic clk = 1'b0, rst = 1'b1;
  logic in_valid = 1'b0, in_dword = 1'b0, in_signed = 1'b0, in_trunc = 1'b0;
  logic [63:0] in_op = '0;
  logic [1:0]  in_rmode = '0;
  logic        out_valid, out_inexact, out_invalid;
  logic [63:0] out_result;
  int total = 0, bad = 0, cycles = 0;
  bit done = 0;

  always #2.5 clk = ~clk;

  fcvt_to_int dut (.*);

  typedef struct packed {
    logic [63:0] op; logic [1:0] rm; logic dw; logic sg; logic tr;
    logic [63:0] res; logic nx; logic nv; logic [7:0] req;
  } vec_t;

  localparam int NV = 35;
  localparam vec_t VEC [NV] = '{
    '{64'h4004000000000000, 2'd0, 1'b1, 1'b1, 1'b0, 64'd2, 1'b1, 1'b0, 8'd2},   // R2
    '{64'h400C000000000000, 2'd0, 1'b1, 1'b1, 1'b0, 64'd4, 1'b1, 1'b0, 8'd2},   // R2
    '{64'hC004000000000000, 2'd0, 1'b1, 1'b1, 1'b0, 64'hFFFFFFFFFFFFFFFE, 1'b1, 1'b0, 8'd2}, // R2
    '{64'h3FF0000000000000, 2'd0, 1'b1, 1'b1, 1'b0, 64'd1, 1'b0, 1'b0, 8'd9},   // R9
    '{64'h3FF8000000000000, 2'd1, 1'b1, 1'b1, 1'b0, 64'd1, 1'b1, 1'b0, 8'd3},   // R3
    '{64'h3FF8000000000000, 2'd2, 1'b1, 1'b1, 1'b0, 64'd2, 1'b1, 1'b0, 8'd3},   // R3
    '{64'hBFF8000000000000, 2'd2, 1'b1, 1'b1, 1'b0, 64'hFFFFFFFFFFFFFFFF, 1'b1, 1'b0, 8'd3}, // R3
    '{64'hBFF8000000000000, 2'd3, 1'b1, 1'b1, 1'b0, 64'hFFFFFFFFFFFFFFFE, 1'b1, 1'b0, 8'd3}, // R3
    '{64'h3FF8000000000000, 2'd2, 1'b1, 1'b1, 1'b1, 64'd1, 1'b1, 1'b0, 8'd4},   // R4
    '{64'hBFF8000000000000, 2'd3, 1'b1, 1'b1, 1'b1, 64'hFFFFFFFFFFFFFFFF, 1'b1, 1'b0, 8'd4}, // R4
    '{64'h41E0000000000000, 2'd0, 1'b0, 1'b1, 1'b0, 64'h000000007FFFFFFF, 1'b0, 1'b1, 8'd5}, // R5
    '{64'hC1E0000000000000, 2'd0, 1'b0, 1'b1, 1'b0, 64'hFFFFFFFF80000000, 1'b0, 1'b0, 8'd5}, // R5
    '{64'h43E0000000000000, 2'd0, 1'b1, 1'b1, 1'b0, 64'h7FFFFFFFFFFFFFFF, 1'b0, 1'b1, 8'd6}, // R6
    '{64'hC3E0000000000000, 2'd0, 1'b1, 1'b1, 1'b0, 64'h8000000000000000, 1'b0, 1'b0, 8'd6}, // R6
    '{64'h41EFFFFFFFE00000, 2'd0, 1'b0, 1'b0, 1'b0, 64'h00000000FFFFFFFF, 1'b0, 1'b0, 8'd5}, // R5
    '{64'h41F0000000000000, 2'd0, 1'b0, 1'b0, 1'b0, 64'h00000000FFFFFFFF, 1'b0, 1'b1, 8'd6}, // R6
    '{64'h43F0000000000000, 2'd0, 1'b1, 1'b0, 1'b0, 64'hFFFFFFFFFFFFFFFF, 1'b0, 1'b1, 8'd6}, // R6
    '{64'h43E0000000000000, 2'd0, 1'b1, 1'b0, 1'b0, 64'h8000000000000000, 1'b0, 1'b0, 8'd5}, // R5
    '{64'hBFE0000000000000, 2'd0, 1'b1, 1'b0, 1'b0, 64'd0, 1'b1, 1'b0, 8'd7},   // R7
    '{64'hBFF8000000000000, 2'd1, 1'b1, 1'b0, 1'b0, 64'd0, 1'b0, 1'b1, 8'd7},   // R7
    '{64'hBFE0000000000000, 2'd3, 1'b1, 1'b0, 1'b0, 64'd0, 1'b0, 1'b1, 8'd7},   // R7
    '{64'h7FF8000000000000, 2'd0, 1'b1, 1'b1, 1'b0, 64'h8000000000000000, 1'b0, 1'b1, 8'd8}, // R8
    '{64'h7FF0000000000001, 2'd0, 1'b0, 1'b1, 1'b0, 64'hFFFFFFFF80000000, 1'b0, 1'b1, 8'd8}, // R8
    '{64'h7FF8000000000000, 2'd0, 1'b1, 1'b0, 1'b0, 64'd0, 1'b0, 1'b1, 8'd8},   // R8
    '{64'h7FF0000000000000, 2'd0, 1'b1, 1'b1, 1'b0, 64'h7FFFFFFFFFFFFFFF, 1'b0, 1'b1, 8'd6}, // R6
    '{64'hFFF0000000000000, 2'd0, 1'b0, 1'b1, 1'b0, 64'hFFFFFFFF80000000, 1'b0, 1'b1, 8'd6}, // R6
    '{64'h0000000000000001, 2'd0, 1'b1, 1'b1, 1'b0, 64'd0, 1'b1, 1'b0, 8'd10},  // R10
    '{64'h0000000000000001, 2'd2, 1'b1, 1'b1, 1'b0, 64'd1, 1'b1, 1'b0, 8'd10},  // R10
    '{64'h8000000000000001, 2'd3, 1'b1, 1'b1, 1'b0, 64'hFFFFFFFFFFFFFFFF, 1'b1, 1'b0, 8'd10}, // R10
    '{64'h8000000000000001, 2'd1, 1'b1, 1'b1, 1'b0, 64'd0, 1'b1, 1'b0, 8'd10},  // R10
    '{64'h8000000000000000, 2'd0, 1'b1, 1'b0, 1'b0, 64'd0, 1'b0, 1'b0, 8'd9},   // R9
    '{64'h3FE0000000000000, 2'd0, 1'b1, 1'b1, 1'b0, 64'd0, 1'b1, 1'b0, 8'd2},   // R2
    '{64'h3FE0000000000000, 2'd2, 1'b1, 1'b1, 1'b0, 64'd1, 1'b1, 1'b0, 8'd3},   // R3
    '{64'h41DFFFFFFFE00000, 2'd0, 1'b0, 1'b1, 1'b0, 64'h000000007FFFFFFF, 1'b0, 1'b1, 8'd6}, // R6
    '{64'h41DFFFFFFFE00000, 2'd1, 1'b0, 1'b1, 1'b0, 64'h000000007FFFFFFF, 1'b1, 1'b0, 8'd9}  // R9
  };

  task automatic check(input string tag, input logic [63:0] got, input logic [63:0] exp);
    total++;
    if (got !== exp) begin
      bad++;
      $display("FAIL %s got=%h exp=%h", tag, got, exp);
    end
  endtask

  task automatic drive(input vec_t v);
    in_valid = 1'b1; in_op = v.op; in_rmode = v.rm;
    in_dword = v.dw; in_signed = v.sg; in_trunc = v.tr;
  endtask

  task automatic judge(input vec_t v, input int idx);
    string t;
    t = $sformatf("R%0d vec%0d", v.req, idx);
    check({t, " result"}, out_result, v.res);
    check({t, " inexact"}, {63'b0, out_inexact}, {63'b0, v.nx});
    check({t, " invalid"}, {63'b0, out_invalid}, {63'b0, v.nv});
  endtask

  initial begin
    while (!done) begin
      @(posedge clk);
      cycles++;
      if (cycles > 20000) begin
        bad++; total++;
        $display("FAIL watchdog expired got=%0d exp<20000", cycles);
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
      end
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    // R11: reset state
    check("R11 valid", {63'b0, out_valid}, 64'd0);
    check("R11 result", out_result, 64'd0);
    check("R11 flags", {62'b0, out_inexact, out_invalid}, 64'd0);
    rst = 1'b0;
    @(negedge clk);
    check("R11 idle after reset", {63'b0, out_valid}, 64'd0);

    for (int i = 0; i < NV; i++) begin
      drive(VEC[i]);
      @(negedge clk);
      in_valid = 1'b0;
      check("R1 not early", {63'b0, out_valid}, 64'd0);
      @(negedge clk);
      check("R1 valid", {63'b0, out_valid}, 64'd1);
      judge(VEC[i], i);
    end
    @(negedge clk);
    check("R1 valid drops", {63'b0, out_valid}, 64'd0);

    // R1: back-to-back, then hold: results stay after valid drops
    drive(VEC[33]);
    @(negedge clk);
    drive(VEC[18]);
    @(negedge clk);
    in_valid = 1'b0;
    check("R1 b2b first valid", {63'b0, out_valid}, 64'd1);
    judge(VEC[33], 33);
    @(negedge clk);
    check("R1 b2b second valid", {63'b0, out_valid}, 64'd1);
    judge(VEC[18], 18);

    // R11: reset with a conversion in flight
    drive(VEC[12]);
    @(negedge clk);
    in_valid = 1'b0;
    rst = 1'b1;
    @(negedge clk);
    rst = 1'b0;
    check("R11 flush valid", {63'b0, out_valid}, 64'd0);
    check("R11 flush result", out_result, 64'd0);
    check("R11 flush flags", {62'b0, out_inexact, out_invalid}, 64'd0);
    @(negedge clk);
    check("R11 no late valid", {63'b0, out_valid}, 64'd0);

    done = 1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule